// File: doc/BRIEF.md
# Cursor-Addressed Text Output Port

This block lets a processor print text to a character-cell frame buffer by writing bytes to a few I/O ports. It does not need to compute memory addresses. It watches an 8-bit-data I/O bus made of an I/O request, a memory request, a write strobe, an address and a data byte. It keeps a column/row cursor and turns every byte written to the character port into one write into the video character memory at the cursor cell. After that write the cursor moves to the next cell, so that consecutive writes fill the screen left to right and top to bottom. Two further ports place the cursor directly.

The frame-buffer side is a write-only stream that has no back-pressure. The character memory is taken to accept a write in every cycle. The write enable therefore acts as a one-cycle valid, and address and data are valid in that same cycle. The bus side also has no handshake: an access is taken on the clock edge at which it is qualified. The cursor position is brought out as plain status pins.

Top module: `cursor_text_port`

## Requirements
- R1: A bus access is acted on only at a rising clock edge where I/O request and write strobe are both high and memory request is low. Any other access changes neither the cursor nor the frame-buffer outputs.
- R2: An accepted write to port 0x90 drives `fb_we` high for exactly the next cycle, with `fb_data` equal to the written byte. `fb_we` is never high except after such a write.
- R3: `fb_addr` during that pulse equals BASE + row*COLS + column, using the cursor as it stood before the write. BASE is 0x4000 and COLS is 40 by default.
- R4: After a character write with the column below COLS-1, the column increases by one and the row is unchanged.
- R5: After a character write at column COLS-1, the column becomes 0 and the row increases by one.
- R6: After a character write at the last cell (column COLS-1, row ROWS-1), the cursor becomes column 0, row 0. ROWS is 30 by default.
- R7: An accepted write to port 0x91 loads the column with the byte. A value of COLS or more is clamped to COLS-1.
- R8: An accepted write to port 0x92 loads the row with the byte. A value of ROWS or more is clamped to ROWS-1.
- R9: Only address bits 7:0 select a port, so the upper address bits have no effect.
- R10: While `rst_n` is low and in the cycle after it, the cursor is column 0, row 0, `fb_we` is low, and `fb_addr` and `fb_data` are zero.
- R11: Accepted writes to any other port number change neither the cursor nor the frame-buffer outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| io_req | input | 1 | I/O request, active high |
| mem_req | input | 1 | Memory request, active high |
| wr_stb | input | 1 | Write strobe, active high |
| bus_addr | input | 16 | Bus address; bits 7:0 carry the port number |
| bus_wdata | input | 8 | Bus write data |
| fb_we | output | 1 | Frame-buffer write enable (one-cycle valid) |
| fb_addr | output | 16 | Frame-buffer byte address |
| fb_data | output | 8 | Character code to be stored |
| cur_col | output | 6 | Current cursor column |
| cur_row | output | 5 | Current cursor row |

## Verification
The bench builds the block with its default geometry: 40 columns, 30 rows and base 0x4000. A 40-column row is not a power of two, so the multiply path of the address generator is the one under test. Clamped cursor loads place the cursor one cell before the end of the screen. This brings both the row wrap and the full-screen wrap within reach after a few writes, with no need for 1200 characters. A long mixed stream then follows. It has random qualifiers, port numbers and upper address bits, and it crosses those wraps many times against the reference model.

// File: rtl/txtport_pkg.sv
package txtport_pkg;
  // Kind of bus access seen by the decoder in one cycle.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CHAR = 2'd1,
    ACC_COL  = 2'd2,
    ACC_ROW  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/txtport_decode.sv
module txtport_decode
  import txtport_pkg::*;
#(
  parameter int AW        = 16,
  parameter int PORT_W    = 8,
  parameter logic [PORT_W-1:0] PORT_CHAR = 8'h90,
  parameter logic [PORT_W-1:0] PORT_COL  = 8'h91,
  parameter logic [PORT_W-1:0] PORT_ROW  = 8'h92
) (
  input  logic          io_req,
  input  logic          mem_req,
  input  logic          wr_stb,
  input  logic [AW-1:0] bus_addr,
  output acc_kind_e     kind
);
  logic              qual;
  logic [PORT_W-1:0] port_no;

  // An I/O write cycle: memory request must be idle.
  assign qual    = io_req & wr_stb & ~mem_req;
  assign port_no = bus_addr[PORT_W-1:0];

  always_comb begin
    kind = ACC_NONE;
    if (qual) begin
      if (port_no == PORT_CHAR)     kind = ACC_CHAR;
      else if (port_no == PORT_COL) kind = ACC_COL;
      else if (port_no == PORT_ROW) kind = ACC_ROW;
    end
  end
endmodule

// File: rtl/txtport_cursor.sv
module txtport_cursor
  import txtport_pkg::*;
#(
  parameter int COLS = 40,
  parameter int ROWS = 30,
  parameter int DW   = 8,
  localparam int XW  = $clog2(COLS),
  localparam int YW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_kind_e     kind,
  input  logic [DW-1:0] wdata,
  output logic [XW-1:0] col,
  output logic [YW-1:0] row
);
  localparam logic [XW-1:0] LAST_X = XW'(COLS - 1);
  localparam logic [YW-1:0] LAST_Y = YW'(ROWS - 1);

  logic [XW-1:0] col_load;
  logic [YW-1:0] row_load;

  // Out-of-range loads saturate to the last cell of the line or screen.
  assign col_load = (int'(wdata) >= COLS) ? LAST_X : wdata[XW-1:0];
  assign row_load = (int'(wdata) >= ROWS) ? LAST_Y : wdata[YW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else begin
      unique case (kind)
        ACC_CHAR: begin
          if (col == LAST_X) begin
            col <= '0;
            row <= (row == LAST_Y) ? '0 : row + 1'b1;
          end else begin
            col <= col + 1'b1;
          end
        end
        ACC_COL: col <= col_load;
        ACC_ROW: row <= row_load;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txtport_fbwrite.sv
module txtport_fbwrite
  import txtport_pkg::*;
#(
  parameter int COLS = 40,
  parameter int ROWS = 30,
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter logic [AW-1:0] BASE = 16'h4000,
  localparam int XW  = $clog2(COLS),
  localparam int YW  = $clog2(ROWS),
  localparam bit COLS_POW2 = (COLS == (1 << XW))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_kind_e     kind,
  input  logic [DW-1:0] wdata,
  input  logic [XW-1:0] col,
  input  logic [YW-1:0] row,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  logic [AW-1:0] line_off;
  logic [AW-1:0] cell_addr;

  // Start of the cursor line: a shift when the width is a power of two.
  generate
    if (COLS_POW2) begin : g_shift
      assign line_off = AW'(row) << XW;
    end else begin : g_mult
      assign line_off = AW'(row) * AW'(COLS);
    end
  endgenerate

  assign cell_addr = BASE + line_off + AW'(col);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we   <= 1'b0;
      addr <= '0;
      data <= '0;
    end else begin
      we <= (kind == ACC_CHAR);
      if (kind == ACC_CHAR) begin
        addr <= cell_addr;
        data <= wdata;
      end
    end
  end
endmodule

// File: rtl/cursor_text_port.sv
module cursor_text_port
  import txtport_pkg::*;
#(
  parameter int COLS = 40,
  parameter int ROWS = 30,
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter logic [AW-1:0] BASE      = 16'h4000,
  parameter logic [7:0]    PORT_CHAR = 8'h90,
  parameter logic [7:0]    PORT_COL  = 8'h91,
  parameter logic [7:0]    PORT_ROW  = 8'h92,
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_req,
  input  logic          mem_req,
  input  logic          wr_stb,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          fb_we,
  output logic [AW-1:0] fb_addr,
  output logic [DW-1:0] fb_data,
  output logic [XW-1:0] cur_col,
  output logic [YW-1:0] cur_row
);
  acc_kind_e kind;

  txtport_decode #(
    .AW(AW), .PORT_W(8),
    .PORT_CHAR(PORT_CHAR), .PORT_COL(PORT_COL), .PORT_ROW(PORT_ROW)
  ) u_decode (
    .io_req(io_req), .mem_req(mem_req), .wr_stb(wr_stb),
    .bus_addr(bus_addr), .kind(kind)
  );

  txtport_cursor #(.COLS(COLS), .ROWS(ROWS), .DW(DW)) u_cursor (
    .clk(clk), .rst_n(rst_n), .kind(kind), .wdata(bus_wdata),
    .col(cur_col), .row(cur_row)
  );

  txtport_fbwrite #(
    .COLS(COLS), .ROWS(ROWS), .AW(AW), .DW(DW), .BASE(BASE)
  ) u_fbwrite (
    .clk(clk), .rst_n(rst_n), .kind(kind), .wdata(bus_wdata),
    .col(cur_col), .row(cur_row),
    .we(fb_we), .addr(fb_addr), .data(fb_data)
  );
endmodule

// File: rtl/cursor_text_port_chk.sv
module cursor_text_port_chk #(
  parameter int COLS = 40,
  parameter int ROWS = 30,
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter logic [AW-1:0] BASE      = 16'h4000,
  parameter logic [7:0]    PORT_CHAR = 8'h90,
  parameter logic [7:0]    PORT_COL  = 8'h91,
  parameter logic [7:0]    PORT_ROW  = 8'h92,
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(ROWS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          io_req,
  input logic          mem_req,
  input logic          wr_stb,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          fb_we,
  input logic [AW-1:0] fb_addr,
  input logic [DW-1:0] fb_data,
  input logic [XW-1:0] cur_col,
  input logic [YW-1:0] cur_row
);
  logic ok_cyc;
  assign ok_cyc = io_req && wr_stb && !mem_req;

  assert_ignore_unqualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_cyc |=> ($stable(cur_col) && $stable(cur_row) && !fb_we));

  assert_we_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> $past(ok_cyc && bus_addr[7:0] == PORT_CHAR));

  assert_data_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_cyc && bus_addr[7:0] == PORT_CHAR) |=> (fb_we && fb_data == $past(bus_wdata)));

  assert_cell_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_cyc && bus_addr[7:0] == PORT_CHAR) |=>
      (fb_addr == BASE + AW'($past(cur_row)) * AW'(COLS) + AW'($past(cur_col))));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_cyc && bus_addr[7:0] == PORT_CHAR && int'(cur_col) < COLS - 1) |=>
      (cur_col == $past(cur_col) + 1'b1 && $stable(cur_row)));

  assert_in_range_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cur_col) < COLS) && (int'(cur_row) < ROWS));

  assert_col_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_cyc && bus_addr[7:0] == PORT_COL) |=>
      (int'(cur_col) == ((int'($past(bus_wdata)) >= COLS) ? COLS - 1 : int'($past(bus_wdata)))));

  assert_row_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_cyc && bus_addr[7:0] == PORT_ROW) |=>
      (int'(cur_row) == ((int'($past(bus_wdata)) >= ROWS) ? ROWS - 1 : int'($past(bus_wdata)))));
endmodule

bind cursor_text_port cursor_text_port_chk #(
  .COLS(COLS), .ROWS(ROWS), .AW(AW), .DW(DW), .BASE(BASE),
  .PORT_CHAR(PORT_CHAR), .PORT_COL(PORT_COL), .PORT_ROW(PORT_ROW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_req(io_req), .mem_req(mem_req),
  .wr_stb(wr_stb), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .fb_we(fb_we), .fb_addr(fb_addr), .fb_data(fb_data),
  .cur_col(cur_col), .cur_row(cur_row)
);

// File: tb/tb_cursor_text_port.sv
`timescale 1ns/1ps
module tb_cursor_text_port;
  localparam int COLS = 40;
  localparam int ROWS = 30;
  localparam int BASE = 16'h4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0, mem_req = 1'b0, wr_stb = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        fb_we;
  logic [15:0] fb_addr;
  logic [7:0]  fb_data;
  logic [5:0]  cur_col;
  logic [4:0]  cur_row;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit started = 0;

  // Reference state
  int m_col = 0, m_row = 0, m_addr = 0, m_data = 0;
  bit m_we = 0;

  always #2 clk = ~clk;

  cursor_text_port dut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .mem_req(mem_req),
    .wr_stb(wr_stb), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_data(fb_data),
    .cur_col(cur_col), .cur_row(cur_row)
  );

  // Behavioural reference: updated on each rising edge from the bus inputs.
  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_col = 0; m_row = 0; m_we = 0; m_addr = 0; m_data = 0;
    end else begin
      m_we = 0;
      if (io_req && wr_stb && !mem_req) begin
        case (int'(bus_addr[7:0]))
          'h90: begin
            m_we = 1;
            m_addr = BASE + m_row * COLS + m_col;
            m_data = bus_wdata;
            m_col = m_col + 1;
            if (m_col == COLS) begin
              m_col = 0;
              m_row = m_row + 1;
              if (m_row == ROWS) m_row = 0;
            end
          end
          'h91: m_col = (int'(bus_wdata) >= COLS) ? COLS - 1 : int'(bus_wdata);
          'h92: m_row = (int'(bus_wdata) >= ROWS) ? ROWS - 1 : int'(bus_wdata);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 fb_we vs model", int'(fb_we), int'(m_we));
      chk("R3 fb_addr vs model", int'(fb_addr), m_addr);
      chk("R2 fb_data vs model", int'(fb_data), m_data);
      chk("R4/R5/R7 cur_col vs model", int'(cur_col), m_col);
      chk("R5/R6/R8 cur_row vs model", int'(cur_row), m_row);
    end
  end

  // Apply one bus cycle and return at the falling edge where its effect shows.
  task automatic bus(bit io, bit mem, bit wr, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_req = io; mem_req = mem; wr_stb = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    io_req = 0; mem_req = 0; wr_stb = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset col", int'(cur_col), 0);
    chk("R10 reset row", int'(cur_row), 0);
    chk("R10 reset we", int'(fb_we), 0);
    @(negedge clk); rst_n = 1;
    chk("R10 after reset addr", int'(fb_addr), 0);
    chk("R10 after reset data", int'(fb_data), 0);

    bus(1, 0, 1, 16'h0091, 8'd200);
    chk("R7 clamp col", int'(cur_col), 39);
    bus(1, 0, 1, 16'h0092, 8'd255);
    chk("R8 clamp row", int'(cur_row), 29);
    bus(1, 0, 1, 16'h0090, 8'h41);
    chk("R2 pulse", int'(fb_we), 1);
    chk("R2 data", int'(fb_data), 'h41);
    chk("R3 last cell addr", int'(fb_addr), 'h44AF);
    chk("R6 wrap col", int'(cur_col), 0);
    chk("R6 wrap row", int'(cur_row), 0);
    @(negedge clk);
    chk("R2 single cycle", int'(fb_we), 0);

    bus(1, 0, 1, 16'h1291, 8'd5);
    chk("R9 upper bits ignored", int'(cur_col), 5);
    bus(1, 1, 1, 16'h0091, 8'd7);
    chk("R1 mem_req blocks", int'(cur_col), 5);
    bus(0, 0, 1, 16'h0090, 8'h55);
    chk("R1 no io_req", int'(fb_we), 0);
    bus(1, 0, 0, 16'h0091, 8'd9);
    chk("R1 no wr_stb", int'(cur_col), 5);
    bus(1, 0, 1, 16'h0093, 8'd9);
    chk("R11 other port col", int'(cur_col), 5);
    chk("R11 other port we", int'(fb_we), 0);

    bus(1, 0, 1, 16'hAB90, 8'h7A);
    chk("R3 addr col5", int'(fb_addr), 'h4005);
    chk("R4 step", int'(cur_col), 6);

    bus(1, 0, 1, 16'h0091, 8'd39);
    bus(1, 0, 1, 16'h0092, 8'd3);
    bus(1, 0, 1, 16'h0090, 8'h20);
    chk("R5 line wrap col", int'(cur_col), 0);
    chk("R5 line wrap row", int'(cur_row), 4);
    chk("R3 addr row3", int'(fb_addr), BASE + 3 * 40 + 39);

    // Back-to-back characters, then a long random stream.
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      io_req = 1; mem_req = 0; wr_stb = 1; bus_addr = 16'h0090; bus_wdata = 8'(i + 'h30);
      @(negedge clk);
    end
    for (int i = 0; i < 6000; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      io_req = ($urandom_range(0, 7) != 0);
      mem_req = ($urandom_range(0, 7) == 0);
      wr_stb = ($urandom_range(0, 7) != 0);
      bus_addr[15:8] = 8'($urandom);
      bus_addr[7:0] = (sel < 6) ? 8'h90 : (sel == 6) ? 8'h91 : (sel == 7) ? 8'h92 :
                      (sel == 8) ? 8'h93 : 8'($urandom);
      bus_wdata = 8'($urandom);
      @(negedge clk);
    end
    io_req = 0; wr_stb = 0;
    rst_n = 0;
    @(negedge clk);
    chk("R10 mid-run reset col", int'(cur_col), 0);
    chk("R10 mid-run reset we", int'(fb_we), 0);
    finish_run();
  end
endmodule